// File: doc/BRIEF.md
# Analog-Shared General-Purpose Digital Port

This block is a small register-mapped digital I/O port that lives on pins also used as analog inputs. Port A is bidirectional: each bit has a direction bit and an output latch bit. Port B is input-only. Software reaches both ports through a simple register bus with an address, read and write strobes, write data, read data and a read-valid strobe.

Analog pins can sit at mid-rail levels, and a digital input stage that samples them draws current. For this reason the two-stage input synchronizers only clock while a bus read of a port data register is in progress. A small read sequencer has three states. `RD_IDLE` waits for a read. The transition idle-to-fill happens when a read strobe arrives; if the read targets a data register, the matching synchronizer is enabled in that cycle. In `RD_FILL` the synchronizer is enabled for its second stage. The fill-to-done transition is unconditional. `RD_DONE` presents the read data with the valid strobe for one cycle, and the done-to-idle transition is unconditional. Read strobes that arrive outside `RD_IDLE` are dropped.

Three mode inputs can override the direction register. The external-address mode turns the three lowest port A pins into outputs that drive a latched 3-bit address. The two trigger modes force bit 3 or bit 4 of port A to be an input. The register map is: address 0 holds port A data, address 1 holds port B data, address 2 holds the port A direction, and address 3 is unused.

Top module: `anagpio_port`

## Requirements
- R1: After reset the direction register and output latch are zero, so `pa_oe` is all zero, `pa_out` is zero, `bus_rvalid` is low, and a read of address 2 returns zero.
- R2: An accepted read (a `bus_rd` pulse while idle) gives exactly one `bus_rvalid` cycle, two clock edges after the edge that samples the strobe. A read strobe issued during a read in progress is ignored. `bus_rdata` is zero whenever `bus_rvalid` is low.
- R3: The value returned for a pin is the level on the pin at the clock edge that accepts the read. A pin change after that edge does not alter the returned value.
- R4: In a read of address 0, a bit whose direction bit is 0 (input), with no mode override, returns the live pin level.
- R5: A bit of port A whose direction bit is 1 (output) drives `pa_oe`=1 and `pa_out` = latch bit, and a read of address 0 returns the latch bit. Writes to address 0 set the latch and writes to address 2 set the direction (1 = output).
- R6: Bits cleared in the implemented-bit masks (`MASK_A`, `MASK_B`) read as 0 at every address, ignore writes, and keep `pa_oe` and `pa_out` at 0.
- R7: While `mux_mode` is 1, port A bits 0..2 have `pa_oe`=1 and `pa_out` equal to the latched address, and a read of address 0 returns the latched address in those bits, whatever the direction bits are.
- R8: While `trig1_mode` is 1, bit 3 of port A has `pa_oe`=0 and reads the live pin. While `trig2_mode` is 1, the same holds for bit 4. Both apply whatever the direction bits are.
- R9: Port B is input-only: a read of address 1 returns `pb_in` masked by `MASK_B`, and writes to address 1 have no effect. A read of address 3 returns zero.
- R10: The address latch loads `maddr_in` only on a clock edge where `maddr_upd` is 1, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one-cycle pulse |
| pa_in | input | W | Port A pin levels |
| pa_out | output | W | Port A output values |
| pa_oe | output | W | Port A output enables |
| pb_in | input | W | Port B pin levels |
| mux_mode | input | 1 | External-address mode on bits 0..2 |
| trig1_mode | input | 1 | Trigger 1 mode, forces bit 3 to input |
| trig2_mode | input | 1 | Trigger 2 mode, forces bit 4 to input |
| maddr_in | input | 3 | Address value to latch |
| maddr_upd | input | 1 | Address latch load strobe |

## Verification
The hardest case to reach from the ports is the sampling instant of the gated synchronizer. The returned value must come from the edge that accepted the read, not from a later one. To reach it, the bench changes the pins on the falling edge right after the accepting edge, while the first stage is still being reloaded, and checks that the returned data holds the old levels.

A second hard case is a read strobe arriving mid-sequence. The bench issues one during `RD_FILL` and checks that only one valid pulse appears.

All other cases are covered by sweeping all eight mode combinations against several direction, latch and pin patterns. For each combination, the expected output enables, outputs and read data are derived bit by bit in the bench.

// File: rtl/anagpio_pkg.sv
package anagpio_pkg;
    localparam int ADDR_W    = 2;
    localparam int MUX_BITS  = 3;
    localparam int TRIG1_BIT = 3;
    localparam int TRIG2_BIT = 4;

    localparam logic [ADDR_W-1:0] REG_PA_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] REG_PB_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] REG_PA_DIR  = 2'd2;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_FILL = 2'd1,
        RD_DONE = 2'd2
    } rd_state_e;
endpackage

// File: rtl/anagpio_sync2.sv
module anagpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else if (en) begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/anagpio_rd_fsm.sv
module anagpio_rd_fsm
    import anagpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              sync_a_en,
    output logic              sync_b_en,
    output logic [ADDR_W-1:0] sel_addr,
    output logic              rvalid
);
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    assign accept = (state_q == RD_IDLE) && rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) addr_q <= addr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd) state_d = RD_FILL;
            RD_FILL: state_d = RD_DONE;
            RD_DONE: state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        sync_a_en = 1'b0;
        sync_b_en = 1'b0;
        rvalid    = 1'b0;
        unique case (state_q)
            RD_IDLE: begin
                sync_a_en = accept && (addr == REG_PA_DATA);
                sync_b_en = accept && (addr == REG_PB_DATA);
            end
            RD_FILL: begin
                sync_a_en = (addr_q == REG_PA_DATA);
                sync_b_en = (addr_q == REG_PB_DATA);
            end
            RD_DONE: rvalid = 1'b1;
            default: rvalid = 1'b0;
        endcase
    end

    assign sel_addr = addr_q;
endmodule

// File: rtl/anagpio_regs.sv
module anagpio_regs
    import anagpio_pkg::*;
#(
    parameter int           W      = 8,
    parameter logic [W-1:0] MASK_A = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [W-1:0]        wdata,
    input  logic [MUX_BITS-1:0] maddr_in,
    input  logic                maddr_upd,
    output logic [W-1:0]        ddr_q,
    output logic [W-1:0]        latch_q,
    output logic [MUX_BITS-1:0] maddr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr_q   <= '0;
            latch_q <= '0;
            maddr_q <= '0;
        end else begin
            if (wr && addr == REG_PA_DATA) latch_q <= wdata & MASK_A;
            if (wr && addr == REG_PA_DIR)  ddr_q   <= wdata & MASK_A;
            if (maddr_upd)                 maddr_q <= maddr_in;
        end
    end
endmodule

// File: rtl/anagpio_view.sv
module anagpio_view
    import anagpio_pkg::*;
#(
    parameter int           W      = 8,
    parameter logic [W-1:0] MASK_A = '1,
    parameter logic [W-1:0] MASK_B = '1
) (
    input  logic                mux_mode,
    input  logic                trig1_mode,
    input  logic                trig2_mode,
    input  logic [W-1:0]        ddr_q,
    input  logic [W-1:0]        latch_q,
    input  logic [MUX_BITS-1:0] maddr_q,
    input  logic [W-1:0]        pa_sync,
    input  logic [W-1:0]        pb_sync,
    input  logic [ADDR_W-1:0]   sel_addr,
    input  logic                rvalid,
    output logic [W-1:0]        pa_out,
    output logic [W-1:0]        pa_oe,
    output logic [W-1:0]        rdata
);
    logic [W-1:0] force_out;
    logic [W-1:0] force_in;
    logic [W-1:0] alt_val;
    logic [W-1:0] drive;
    logic [W-1:0] out_raw;
    logic [W-1:0] a_view;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < MUX_BITS) begin : g_mux
            assign force_out[i] = mux_mode;
            assign alt_val[i]   = maddr_q[i];
        end else begin : g_plain
            assign force_out[i] = 1'b0;
            assign alt_val[i]   = 1'b0;
        end
        if (i == TRIG1_BIT) begin : g_t1
            assign force_in[i] = trig1_mode;
        end else if (i == TRIG2_BIT) begin : g_t2
            assign force_in[i] = trig2_mode;
        end else begin : g_nt
            assign force_in[i] = 1'b0;
        end
    end

    assign drive   = force_out | (ddr_q & ~force_in);
    assign out_raw = (force_out & alt_val) | (~force_out & latch_q);
    assign pa_oe   = drive & MASK_A;
    assign pa_out  = out_raw & MASK_A;
    assign a_view  = ((drive & out_raw) | (~drive & pa_sync)) & MASK_A;

    always_comb begin
        rdata = '0;
        if (rvalid) begin
            unique case (sel_addr)
                REG_PA_DATA: rdata = a_view;
                REG_PB_DATA: rdata = pb_sync & MASK_B;
                REG_PA_DIR:  rdata = ddr_q & MASK_A;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/anagpio_port.sv
module anagpio_port
    import anagpio_pkg::*;
#(
    parameter int           W      = 8,
    parameter logic [W-1:0] MASK_A = 8'hDF,
    parameter logic [W-1:0] MASK_B = 8'h3F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    output logic                bus_rvalid,
    input  logic [W-1:0]        pa_in,
    output logic [W-1:0]        pa_out,
    output logic [W-1:0]        pa_oe,
    input  logic [W-1:0]        pb_in,
    input  logic                mux_mode,
    input  logic                trig1_mode,
    input  logic                trig2_mode,
    input  logic [MUX_BITS-1:0] maddr_in,
    input  logic                maddr_upd
);
    logic              sync_a_en;
    logic              sync_b_en;
    logic [ADDR_W-1:0] sel_addr;
    logic [W-1:0]      pa_sync;
    logic [W-1:0]      pb_sync;
    logic [W-1:0]      ddr_q;
    logic [W-1:0]      latch_q;
    logic [MUX_BITS-1:0] maddr_q;

    anagpio_rd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .sync_a_en (sync_a_en),
        .sync_b_en (sync_b_en),
        .sel_addr  (sel_addr),
        .rvalid    (bus_rvalid)
    );

    anagpio_sync2 #(.W(W)) u_sync_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sync_a_en),
        .d     (pa_in),
        .q     (pa_sync)
    );

    anagpio_sync2 #(.W(W)) u_sync_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sync_b_en),
        .d     (pb_in),
        .q     (pb_sync)
    );

    anagpio_regs #(.W(W), .MASK_A(MASK_A)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .maddr_in  (maddr_in),
        .maddr_upd (maddr_upd),
        .ddr_q     (ddr_q),
        .latch_q   (latch_q),
        .maddr_q   (maddr_q)
    );

    anagpio_view #(.W(W), .MASK_A(MASK_A), .MASK_B(MASK_B)) u_view (
        .mux_mode   (mux_mode),
        .trig1_mode (trig1_mode),
        .trig2_mode (trig2_mode),
        .ddr_q      (ddr_q),
        .latch_q    (latch_q),
        .maddr_q    (maddr_q),
        .pa_sync    (pa_sync),
        .pb_sync    (pb_sync),
        .sel_addr   (sel_addr),
        .rvalid     (bus_rvalid),
        .pa_out     (pa_out),
        .pa_oe      (pa_oe),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/anagpio_port_chk.sv
module anagpio_port_chk
    import anagpio_pkg::*;
#(
    parameter int           W      = 8,
    parameter logic [W-1:0] MASK_A = 8'hDF,
    parameter logic [W-1:0] MASK_B = 8'h3F
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [W-1:0]        bus_wdata,
    input logic [W-1:0]        bus_rdata,
    input logic                bus_rvalid,
    input logic [W-1:0]        pa_in,
    input logic [W-1:0]        pa_out,
    input logic [W-1:0]        pa_oe,
    input logic [W-1:0]        pb_in,
    input logic                mux_mode,
    input logic                trig1_mode,
    input logic                trig2_mode,
    input logic [MUX_BITS-1:0] maddr_in,
    input logic                maddr_upd
);
    // R2
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    // R2
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

    // R6
    unimpl_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_oe & ~MASK_A) == '0) && ((pa_out & ~MASK_A) == '0));

    // R7
    mux_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |-> ((pa_oe[MUX_BITS-1:0] & MASK_A[MUX_BITS-1:0]) == MASK_A[MUX_BITS-1:0]));

    // R8
    trig1_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig1_mode |-> !pa_oe[TRIG1_BIT]);

    // R8
    trig2_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig2_mode |-> !pa_oe[TRIG2_BIT]);

    // R10
    maddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode && $past(maddr_upd) && $past(rst_n))
            |-> (pa_out[MUX_BITS-1:0] == ($past(maddr_in) & MASK_A[MUX_BITS-1:0])));
endmodule

bind anagpio_port anagpio_port_chk #(.W(W), .MASK_A(MASK_A), .MASK_B(MASK_B)) u_chk (.*);

// File: tb/sim_anagpio_port.sv
module sim_anagpio_port;
    localparam int          CLK_P = 10;
    localparam int          W     = 8;
    localparam logic [7:0]  MA    = 8'hDF;
    localparam logic [7:0]  MB    = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [7:0] pa_in = '0;
    logic [7:0] pa_out;
    logic [7:0] pa_oe;
    logic [7:0] pb_in = '0;
    logic       mux_mode = 1'b0;
    logic       trig1_mode = 1'b0;
    logic       trig2_mode = 1'b0;
    logic [2:0] maddr_in = '0;
    logic       maddr_upd = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    anagpio_port #(.W(W), .MASK_A(MA), .MASK_B(MB)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pa_in      (pa_in),
        .pa_out     (pa_out),
        .pa_oe      (pa_oe),
        .pb_in      (pb_in),
        .mux_mode   (mux_mode),
        .trig1_mode (trig1_mode),
        .trig2_mode (trig2_mode),
        .maddr_in   (maddr_in),
        .maddr_upd  (maddr_upd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic upd_maddr(input logic [2:0] v);
        @(negedge clk);
        maddr_in = v; maddr_upd = 1'b1;
        @(negedge clk);
        maddr_upd = 1'b0;
        maddr_in = ~v;
    endtask

    // Read: strobe sampled at edge k, valid after edge k+1.
    task automatic rd_reg(input logic [1:0] a, input string tag, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk({tag, " R2 early"}, {7'b0, bus_rvalid}, 8'h00);
        @(negedge clk);
        chk({tag, " R2 valid"}, {7'b0, bus_rvalid}, 8'h01);
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        chk({tag, " R2 single"}, {7'b0, bus_rvalid}, 8'h00);
    endtask

    function automatic logic [7:0] f_drive(input logic [7:0] ddr, input logic mx,
                                           input logic t1, input logic t2);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic fo, fi;
            fo = mx && (i < 3);
            fi = (t1 && i == 3) || (t2 && i == 4);
            r[i] = fo || (ddr[i] && !fi);
        end
        return r & MA;
    endfunction

    function automatic logic [7:0] f_out(input logic [7:0] lat, input logic mx,
                                         input logic [2:0] ma);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (mx && i < 3) ? ma[i % 3] : lat[i];
        return r & MA;
    endfunction

    function automatic logic [7:0] f_read_a(input logic [7:0] ddr, input logic [7:0] lat,
                                            input logic [7:0] pin, input logic mx,
                                            input logic t1, input logic t2,
                                            input logic [2:0] ma);
        logic [7:0] dv, ov, r;
        dv = f_drive(ddr, mx, t1, t2);
        ov = f_out(lat, mx, ma);
        for (int i = 0; i < 8; i++)
            r[i] = dv[i] ? ov[i] : pin[i];
        return r & MA;
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] ddr_p [4];
        logic [7:0] lat_p [4];
        logic [7:0] pin_p [4];
        ddr_p[0] = 8'h00; ddr_p[1] = 8'hFF; ddr_p[2] = 8'h5A; ddr_p[3] = 8'hC3;
        lat_p[0] = 8'hFF; lat_p[1] = 8'h96; lat_p[2] = 8'h3C; lat_p[3] = 8'h00;
        pin_p[0] = 8'hA5; pin_p[1] = 8'h00; pin_p[2] = 8'hFF; pin_p[3] = 8'h69;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pa_oe, 8'h00);
        chk("R1 out", pa_out, 8'h00);
        chk("R1 rvalid", {7'b0, bus_rvalid}, 8'h00);
        rd_reg(2'd2, "R1 dir", 8'h00);
        // R10: latch reset value visible in mux mode
        mux_mode = 1'b1;
        @(negedge clk);
        chk("R10 reset addr", pa_out & 8'h07, 8'h00);
        mux_mode = 1'b0;

        // Mode sweep
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 4; p++) begin
                logic [2:0] ma;
                logic mx, t1, t2;
                mx = m[0]; t1 = m[1]; t2 = m[2];
                ma = 3'(m * 3 + p);
                mux_mode = mx; trig1_mode = t1; trig2_mode = t2;
                wr_reg(2'd2, ddr_p[p]);
                wr_reg(2'd0, lat_p[p]);
                upd_maddr(ma);
                pa_in = pin_p[p];
                pb_in = ~pin_p[p];
                @(negedge clk);
                // R5 R6 R7 R8 R10 outputs
                chk("R5/R7/R8 oe", pa_oe, f_drive(ddr_p[p], mx, t1, t2));
                chk("R5/R7/R10 out", pa_out, f_out(lat_p[p], mx, ma));
                rd_reg(2'd0, "R4/R5/R7/R8 portA",
                       f_read_a(ddr_p[p], lat_p[p], pin_p[p], mx, t1, t2, ma));
                rd_reg(2'd2, "R5/R6 dir", ddr_p[p] & MA);
                rd_reg(2'd1, "R9 portB", ~pin_p[p] & MB);
            end
        end
        mux_mode = 1'b0; trig1_mode = 1'b0; trig2_mode = 1'b0;

        // R6: write of all ones into unimplemented bit positions
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd0, 8'hFF);
        @(negedge clk);
        chk("R6 oe mask", pa_oe, MA);
        chk("R6 out mask", pa_out, MA);
        rd_reg(2'd2, "R6 dir mask", MA);

        // R9: port B write ignored, address 3 reads zero
        wr_reg(2'd2, 8'h00);
        pb_in = 8'hFF;
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, "R9 portB write ignored", MB);
        rd_reg(2'd3, "R9 unused addr", 8'h00);

        // R10: address latch ignores maddr_in without strobe
        mux_mode = 1'b1;
        upd_maddr(3'b101);
        maddr_in = 3'b010;
        repeat (2) @(negedge clk);
        chk("R10 hold", pa_out & 8'h07, 8'h05);
        mux_mode = 1'b0;

        // R3: pin changes just after the accepting edge
        pa_in = 8'h3C;
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        pa_in = 8'hC3;
        @(negedge clk);
        chk("R3 sample instant", bus_rdata, 8'h3C & MA);
        @(negedge clk);
        rd_reg(2'd0, "R3 next read", 8'hC3 & MA);

        // R2: read strobe during fill is ignored
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1;
        @(negedge clk);
        // still high in RD_FILL: must be dropped
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R2 busy valid", {7'b0, bus_rvalid}, 8'h01);
        @(negedge clk);
        chk("R2 busy drop", {7'b0, bus_rvalid}, 8'h00);
        @(negedge clk);
        chk("R2 busy drop2", {7'b0, bus_rvalid}, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule